// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter that serves up to twelve multiplexed inputs. Software writes a control word (enable, start, continuous-mode select, done-flag clear, interrupt enable and a 3-bit clock-divider code) and a separate 4-bit input-select word. The block divides the system clock down to a conversion clock. It then runs the binary search one bit per conversion-clock cycle, driving the trial code for an external DAC and reading back a 1-bit comparator decision. At the end it publishes the 10-bit result with a one-cycle completion pulse, a sticky done flag and an interrupt request.

The first conversion requested after the block is enabled is preceded by a 25-cycle calibration pass. Software sees this only as a longer busy time. In continuous mode the converter restarts on the same edge that completes a result, and a new input selection is picked up only at a conversion boundary. This lets software hop through channels from the completion interrupt without disturbing the conversion in flight. The comparator, the DAC and the analog multiplexer sit outside the block and are seen here as plain digital ports.

Top module: `sar_sequencer`

## Requirements
- R1: The divider code selects the conversion-clock period D in system cycles: codes 0 and 1 give D=2, and code k from 2 to 7 gives D=2^k.
- R2: The divider counter is held at zero while the enable bit is 0 and runs freely while it is 1. A control write that sets enable together with start therefore produces its first conversion-clock rising edge exactly D cycles after the write edge.
- R3: A start written while the block is enabled and idle (not the first start after enabling) starts a conversion on the next conversion-clock rising edge. The completion pulse follows between 12D+1 and 13D system cycles after the write edge.
- R4: A normal conversion lasts 12 conversion-clock cycles. In continuous mode, completion pulses are exactly 12D system cycles apart.
- R5: The sample-and-hold strobe is one system cycle wide and rises 1.5 conversion-clock cycles after the conversion starts, that is 10.5D system cycles before that conversion's completion pulse.
- R6: The first start after enabling, or a start written together with enable, runs a 25-cycle calibration pass and then the requested conversion. This gives exactly one completion pulse, 37D cycles after the first rising edge (38D after the write edge), and busy stays 1 throughout.
- R7: The search tests bits 9 down to 0, one per conversion-clock cycle after the sample point. It keeps a bit when cmp_in is 1 (input at or above trial_code), so an ideal comparator yields the input code, including 0 and 1023. In single mode the completion edge raises result_valid and done_flag and drops busy together.
- R8: In continuous mode the next conversion starts on the completion edge and busy stays 1. After the continuous bit is written 0, the conversion in flight completes, busy drops on that edge, and no further result follows.
- R9: An input-select write takes effect only at the start of the next conversion, so a write during a conversion does not change that conversion's result. Codes 12 to 15 select input 0, and mux_sel shows the selected input number (0 to 11).
- R10: Writing enable 0 aborts a conversion in progress: busy and trial_code return to 0 and no completion pulse occurs. A start written with enable 0 leaves busy at 0, and writing start 0 during a conversion does not stop it.
- R11: done_flag is cleared by a control write with the done-clear bit at 1 or by a pulse on irq_ack. irq is 1 exactly when done_flag and the interrupt-enable bit are both 1.
- R12: After reset, busy, done_flag, irq, sh_strobe, mux_sel, trial_code, result and result_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_enable | input | 1 | Enable bit of the control word |
| ctrl_start | input | 1 | Start bit; a 1 requests a conversion, a 0 does nothing |
| ctrl_freerun | input | 1 | Continuous conversion mode select |
| ctrl_done_clr | input | 1 | Write 1 to clear the done flag |
| ctrl_irq_en | input | 1 | Interrupt enable bit |
| ctrl_prescale | input | 3 | Conversion clock divider code |
| chan_we | input | 1 | Input-select write strobe |
| chan_wdata | input | 4 | Requested input number |
| irq_ack | input | 1 | Interrupt acknowledge, clears the done flag |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above trial_code |
| busy | output | 1 | Start bit readback, high while a conversion is pending or running |
| done_flag | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | Interrupt request |
| sh_strobe | output | 1 | One-cycle sample-and-hold strobe |
| mux_sel | output | 4 | Input selected for the current conversion |
| trial_code | output | 10 | DAC trial code for the search |
| result | output | 10 | Last completed result |
| result_valid | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is a channel write or a continuous-mode clear that lands strictly inside a running conversion. The update must be deferred to the boundary rather than applied immediately. The bench reaches this state in continuous mode by waiting for a completion pulse, which marks a fresh conversion start, and then writing a few cycles later. It then checks that the next result still comes from the old input and the one after from the new input. A comparator model driven by per-input codes makes every result identify the input that produced it. The divider codes are walked from a disabled state, so every latency is exact rather than a range.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  // Divider exponent: codes 0 and 1 both give divide-by-2.
  function automatic int unsigned div_shift(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int SEL_W = 3,
  parameter int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  import sar_seq_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_c;
  logic [CNT_W-1:0] half_c;
  int unsigned      sh;

  always_comb begin
    sh     = div_shift(int'(sel_i));
    top_c  = CNT_W'((1 << sh) - 1);
    half_c = CNT_W'((1 << (sh - 1)) - 1);
  end

  assign rise_o = run_i && (cnt_q >= top_c);
  assign fall_o = run_i && (cnt_q == half_c);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q >= top_c) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: a conversion-clock rising edge never repeats on consecutive cycles
  a_r1_rise_spacing: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

  // R2: counter released from zero only while running
  a_r2_held_when_off: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !rise_o && (cnt_q == '0));

endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            init_i,
  input  logic            step_i,
  input  logic            cmp_i,
  output logic [BITS-1:0] trial_o,
  output logic [BITS-1:0] final_o
);
  localparam logic [BITS-1:0] MSB_ONE = {1'b1, {(BITS-1){1'b0}}};

  logic [BITS-1:0] trial_q;
  logic [BITS-1:0] mask_q;
  logic [BITS-1:0] kept;

  // keep the bit under test when the input is at or above the trial code
  assign kept    = cmp_i ? trial_q : (trial_q & ~mask_q);
  assign final_o = kept;
  assign trial_o = trial_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (init_i) begin
      trial_q <= MSB_ONE;
      mask_q  <= MSB_ONE;
    end else if (step_i) begin
      trial_q <= kept | (mask_q >> 1);
      mask_q  <= mask_q >> 1;
    end
  end

  // R7: exactly one bit under test at a time
  a_r7_mask_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_q));

  // R7: the sequencer never steps past bit 0
  a_r7_step_in_range: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (mask_q != '0));

endmodule

// File: rtl/sar_regs.sv
module sar_regs #(
  parameter int SEL_W = 3,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we_i,
  input  logic             wr_en_i,
  input  logic             wr_fr_i,
  input  logic             wr_dclr_i,
  input  logic             wr_ie_i,
  input  logic [SEL_W-1:0] wr_ps_i,
  input  logic             chan_we_i,
  input  logic [CH_W-1:0]  chan_wdata_i,
  input  logic             done_set_i,
  input  logic             irq_ack_i,
  output logic             en_o,
  output logic             fr_o,
  output logic [SEL_W-1:0] ps_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             done_o,
  output logic             irq_o
);
  logic ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      fr_o   <= 1'b0;
      ie_q   <= 1'b0;
      ps_o   <= '0;
      chan_o <= '0;
      done_o <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        en_o <= wr_en_i;
        fr_o <= wr_fr_i;
        ie_q <= wr_ie_i;
        ps_o <= wr_ps_i;
      end
      if (chan_we_i) chan_o <= chan_wdata_i;
      if (done_set_i) begin
        done_o <= 1'b1;
      end else if (irq_ack_i || (ctrl_we_i && wr_dclr_i)) begin
        done_o <= 1'b0;
      end
    end
  end

  assign irq_o = done_o & ie_q;

  // R7: completion always leaves the flag set
  a_r7_done_on_complete: assert property (@(posedge clk) disable iff (rst)
    done_set_i |=> done_o);

  // R11: acknowledge clears the flag unless a new completion arrives
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && !done_set_i) |=> !done_o);

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm #(
  parameter int BITS     = 10,
  parameter int CAL_CYC  = 25,
  parameter int CH_W     = 4,
  parameter int CHANNELS = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            fr_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            start_wr_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic [BITS-1:0] final_i,
  output logic            busy_o,
  output logic            strobe_o,
  output logic [CH_W-1:0] sel_o,
  output logic            init_o,
  output logic            step_o,
  output logic            clr_o,
  output logic            complete_o,
  output logic [BITS-1:0] result_o,
  output logic            valid_o
);
  import sar_seq_pkg::*;

  localparam int NORM_CYC = BITS + 2;
  localparam int PH_W     = $clog2(CAL_CYC + 1);

  seq_state_e      state;
  logic [PH_W-1:0] ph;
  logic            sb;
  logic            cal_req;
  logic            go;
  logic            cal_last;
  logic            norm_last;
  logic            latch_ch;
  logic [CH_W-1:0] chan_dec;

  assign go        = rise_i && (state == ST_IDLE) && sb;
  assign cal_last  = rise_i && (state == ST_CAL) && (ph == PH_W'(CAL_CYC - 1));
  assign norm_last = rise_i && (state == ST_CONV) && (ph == PH_W'(NORM_CYC - 1));
  assign init_o    = rise_i && (state == ST_CONV) && (ph == PH_W'(1));
  assign step_o    = rise_i && (state == ST_CONV) && (ph >= PH_W'(2));
  assign clr_o     = !en_i;
  assign complete_o = norm_last;

  // channel is sampled only where a measured conversion begins
  assign latch_ch = (go && !cal_req) || cal_last || (norm_last && fr_i);
  assign chan_dec = (chan_i >= CH_W'(CHANNELS)) ? '0 : chan_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ph       <= '0;
      sb       <= 1'b0;
      cal_req  <= 1'b1;
      strobe_o <= 1'b0;
      valid_o  <= 1'b0;
      result_o <= '0;
      sel_o    <= '0;
    end else begin
      strobe_o <= en_i && fall_i && (state == ST_CONV) && (ph == PH_W'(1));
      valid_o  <= norm_last;
      if (latch_ch) sel_o <= chan_dec;
      if (!en_i) begin
        state   <= ST_IDLE;
        ph      <= '0;
        sb      <= 1'b0;
        cal_req <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            if (go) begin
              ph <= '0;
              if (cal_req) begin
                state   <= ST_CAL;
                cal_req <= 1'b0;
              end else begin
                state <= ST_CONV;
              end
            end
          end
          ST_CAL: begin
            if (rise_i) begin
              if (cal_last) begin
                state <= ST_CONV;
                ph    <= '0;
              end else begin
                ph <= ph + 1'b1;
              end
            end
          end
          ST_CONV: begin
            if (rise_i) begin
              if (norm_last) begin
                result_o <= final_i;
                ph       <= '0;
                if (!fr_i) begin
                  state <= ST_IDLE;
                  sb    <= 1'b0;
                end
              end else begin
                ph <= ph + 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
      if (start_wr_i) sb <= 1'b1;
    end
  end

  assign busy_o = sb;

  // R6: start bit stays up for the whole calibration and conversion
  a_r6_busy_while_active: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> sb);

  // R10: dropping enable returns to idle without a result
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (state == ST_IDLE) && !valid_o);

  // R7: single-mode completion clears the start bit
  a_r7_single_clears: assert property (@(posedge clk) disable iff (rst)
    (norm_last && !fr_i && !start_wr_i) |=> !sb);

  // R5: the sample strobe falls inside the second cycle of a measured conversion
  a_r5_strobe_place: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (state == ST_CONV) && (ph == PH_W'(1)));

  // R4: completion is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9: the selected input is always a real input
  a_r9_sel_range: assert property (@(posedge clk) disable iff (rst)
    sel_o < CH_W'(CHANNELS));

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int BITS     = 10,
  parameter int CAL_CYC  = 25,
  parameter int SEL_W    = 3,
  parameter int CH_W     = 4,
  parameter int CHANNELS = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  logic            ctrl_enable,
  input  logic            ctrl_start,
  input  logic            ctrl_freerun,
  input  logic            ctrl_done_clr,
  input  logic            ctrl_irq_en,
  input  logic [SEL_W-1:0] ctrl_prescale,
  input  logic            chan_we,
  input  logic [CH_W-1:0] chan_wdata,
  input  logic            irq_ack,
  input  logic            cmp_in,
  output logic            busy,
  output logic            done_flag,
  output logic            irq,
  output logic            sh_strobe,
  output logic [CH_W-1:0] mux_sel,
  output logic [BITS-1:0] trial_code,
  output logic [BITS-1:0] result,
  output logic            result_valid
);
  logic             en_q;
  logic             fr_q;
  logic [SEL_W-1:0] ps_q;
  logic [CH_W-1:0]  chan_q;
  logic             rise;
  logic             fall;
  logic             init;
  logic             step;
  logic             clr;
  logic             complete;
  logic             start_wr;
  logic [BITS-1:0]  final_code;

  assign start_wr = ctrl_we && ctrl_start && ctrl_enable;

  sar_regs #(.SEL_W(SEL_W), .CH_W(CH_W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl_we_i   (ctrl_we),
    .wr_en_i     (ctrl_enable),
    .wr_fr_i     (ctrl_freerun),
    .wr_dclr_i   (ctrl_done_clr),
    .wr_ie_i     (ctrl_irq_en),
    .wr_ps_i     (ctrl_prescale),
    .chan_we_i   (chan_we),
    .chan_wdata_i(chan_wdata),
    .done_set_i  (complete),
    .irq_ack_i   (irq_ack),
    .en_o        (en_q),
    .fr_o        (fr_q),
    .ps_o        (ps_q),
    .chan_o      (chan_q),
    .done_o      (done_flag),
    .irq_o       (irq)
  );

  sar_prescaler #(.SEL_W(SEL_W)) div_i (
    .clk   (clk),
    .rst   (rst),
    .run_i (en_q),
    .sel_i (ps_q),
    .rise_o(rise),
    .fall_o(fall)
  );

  sar_fsm #(
    .BITS(BITS), .CAL_CYC(CAL_CYC), .CH_W(CH_W), .CHANNELS(CHANNELS)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_q),
    .fr_i      (fr_q),
    .chan_i    (chan_q),
    .start_wr_i(start_wr),
    .rise_i    (rise),
    .fall_i    (fall),
    .final_i   (final_code),
    .busy_o    (busy),
    .strobe_o  (sh_strobe),
    .sel_o     (mux_sel),
    .init_o    (init),
    .step_o    (step),
    .clr_o     (clr),
    .complete_o(complete),
    .result_o  (result),
    .valid_o   (result_valid)
  );

  sar_search #(.BITS(BITS)) srch_i (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .init_i (init),
    .step_i (step),
    .cmp_i  (cmp_in),
    .trial_o(trial_code),
    .final_o(final_code)
  );

endmodule

// File: tb/sar_sequencer_tb.sv
`timescale 1ns/1ps
module sar_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0, ctrl_enable = 1'b0, ctrl_start = 1'b0;
  logic       ctrl_freerun = 1'b0, ctrl_done_clr = 1'b0, ctrl_irq_en = 1'b0;
  logic [2:0] ctrl_prescale = '0;
  logic       chan_we = 1'b0;
  logic [3:0] chan_wdata = '0;
  logic       irq_ack = 1'b0;
  logic       cmp_in;
  logic       busy, done_flag, irq, sh_strobe, result_valid;
  logic [3:0] mux_sel;
  logic [9:0] trial_code, result;

  logic [9:0] volt [16];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // ideal comparator: input at or above trial code
  assign cmp_in = (volt[mux_sel] >= trial_code);

  sar_sequencer dut_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
    .ctrl_start(ctrl_start), .ctrl_freerun(ctrl_freerun),
    .ctrl_done_clr(ctrl_done_clr), .ctrl_irq_en(ctrl_irq_en),
    .ctrl_prescale(ctrl_prescale), .chan_we(chan_we), .chan_wdata(chan_wdata),
    .irq_ack(irq_ack), .cmp_in(cmp_in), .busy(busy), .done_flag(done_flag),
    .irq(irq), .sh_strobe(sh_strobe), .mux_sel(mux_sel),
    .trial_code(trial_code), .result(result), .result_valid(result_valid)
  );

  // prescale code, written input, expected input, expected divisor
  localparam int VEC [8][4] = '{
    '{0,  3,  3,   2}, '{1, 12,  0,   2}, '{2,  7,  7,   4}, '{3, 15,  0,   8},
    '{4, 11, 11,  16}, '{5,  0,  0,  32}, '{6,  5,  5,  64}, '{7,  9,  9, 128}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input bit en, input bit st, input bit fr,
                            input bit dc, input bit ie, input logic [2:0] ps);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_enable = en; ctrl_start = st; ctrl_freerun = fr;
    ctrl_done_clr = dc; ctrl_irq_en = ie; ctrl_prescale = ps;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic chan_write(input logic [3:0] c);
    @(negedge clk);
    chan_we = 1'b1; chan_wdata = c;
    @(negedge clk);
    chan_we = 1'b0;
  endtask

  task automatic wait_valid(input int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!result_valid && n < maxc);
  endtask

  task automatic count_valid(input int cycles, output int k);
    k = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (result_valid) k++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, s, p, k, d;
    for (int c = 0; c < 16; c++) volt[c] = 10'((c * 89 + 37) % 1024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check("R12 busy", busy, 0);
    check("R12 done", done_flag, 0);
    check("R12 irq", irq, 0);
    check("R12 outputs", int'(sh_strobe) + int'(mux_sel) + int'(trial_code)
          + int'(result) + int'(result_valid), 0);

    // table walk: each divider code from a disabled state, continuous mode
    for (int v = 0; v < 8; v++) begin
      d = VEC[v][3];
      ctrl_write(0, 0, 0, 1, 0, 3'(VEC[v][0]));
      chan_write(4'(VEC[v][1]));
      ctrl_write(1, 1, 1, 0, 0, 3'(VEC[v][0]));
      wait_valid(40 * d + 10, n);
      check("R1 R2 R6 first latency", n, 38 * d);
      check("R7 R9 result", result, volt[VEC[v][2]]);
      check("R9 decoded select", mux_sel, VEC[v][2]);
      s = 0;
      do begin @(negedge clk); s++; end while (!sh_strobe && s < 20 * d);
      p = s;
      do begin @(negedge clk); p++; end while (!result_valid && p < 20 * d);
      check("R4 period", p, 12 * d);
      check("R5 strobe to completion", p - s, (21 * d) / 2);
      check("R8 busy held in continuous", busy, 1);
    end

    // R6 R7 R11: single mode with D=8
    ctrl_write(0, 0, 0, 1, 0, 3'd3);
    check("R11 clear by write", done_flag, 0);
    chan_write(4'd2);
    ctrl_write(1, 1, 0, 0, 1, 3'd3);
    repeat (100) @(negedge clk);
    check("R6 busy during calibration", busy, 1);
    wait_valid(400, n);
    check("R6 latency incl. calibration", n + 100, 304);
    check("R7 busy drops at completion", busy, 0);
    check("R7 done set", done_flag, 1);
    check("R11 irq follows done", irq, 1);
    check("R7 result", result, volt[2]);

    // R3: later start waits for next rising edge only
    ctrl_write(1, 1, 0, 0, 1, 3'd3);
    wait_valid(200, n);
    checks++;
    if (n < 96 || n > 103) begin
      errors++;
      $display("FAIL R3 latency actual=%0d expected=97..104", n + 1);
    end
    // R11: acknowledge clears
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R11 ack clears done", done_flag, 0);
    check("R11 ack drops irq", irq, 0);

    // R11: interrupt masked
    ctrl_write(1, 1, 0, 0, 0, 3'd3);
    wait_valid(200, n);
    check("R11 done with irq disabled", done_flag, 1);
    check("R11 irq masked", irq, 0);
    ctrl_write(1, 0, 0, 1, 0, 3'd3);
    check("R11 write-one clear", done_flag, 0);

    // R10: writing start 0 mid-conversion has no effect
    ctrl_write(1, 1, 0, 0, 0, 3'd3);
    repeat (20) @(negedge clk);
    ctrl_write(1, 0, 0, 0, 0, 3'd3);
    check("R10 start-0 keeps busy", busy, 1);
    wait_valid(200, n);
    check("R10 conversion still completes", result_valid, 1);
    check("R10 result after start-0", result, volt[2]);

    // R10: abort by disabling
    ctrl_write(1, 1, 0, 0, 0, 3'd3);
    repeat (30) @(negedge clk);
    ctrl_write(0, 0, 0, 0, 0, 3'd3);
    @(negedge clk);
    check("R10 abort busy", busy, 0);
    check("R10 abort trial", trial_code, 0);
    count_valid(400, k);
    check("R10 no result after abort", k, 0);
    ctrl_write(0, 1, 0, 0, 0, 3'd3);
    @(negedge clk);
    check("R10 start ignored while disabled", busy, 0);

    // R8 R9: continuous mode, deferred channel, stop
    chan_write(4'd4);
    ctrl_write(1, 1, 1, 0, 0, 3'd0);
    wait_valid(100, n);
    check("R9 first input", result, volt[4]);
    repeat (5) @(negedge clk);
    chan_write(4'd8);
    wait_valid(100, n);
    check("R9 write deferred", result, volt[4]);
    check("R8 restarted busy", busy, 1);
    wait_valid(100, n);
    check("R9 new input applied", result, volt[8]);
    check("R9 select shows input", mux_sel, 8);
    repeat (3) @(negedge clk);
    ctrl_write(1, 0, 0, 0, 0, 3'd0);
    wait_valid(100, n);
    check("R8 in-flight completes", result_valid, 1);
    check("R8 busy drops on stop", busy, 0);
    count_valid(80, k);
    check("R8 no further result", k, 0);

    // R7: boundary codes, code 14 maps to input 0
    volt[0] = 10'd1023;
    volt[1] = 10'd0;
    chan_write(4'd14);
    ctrl_write(1, 1, 0, 0, 0, 3'd0);
    wait_valid(100, n);
    check("R7 full scale", result, 1023);
    check("R9 code 14 selects 0", mux_sel, 0);
    chan_write(4'd1);
    ctrl_write(1, 1, 0, 0, 0, 3'd0);
    wait_valid(100, n);
    check("R7 zero scale", result, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule